// File: doc/BRIEF.md
# Filter Accelerator Control and Request Logic

This block holds the control settings of a fixed-point filter accelerator. It sits between a simple memory-mapped register write/read port and the accelerator's buffer and error status lines. Software programs five interrupt-source enables, two DMA-channel enables and an output clipping mode. The block turns these settings and the live buffer occupancy flags into one combined interrupt line and two DMA request lines. All three are level-driven: each stays active for as long as its condition holds.

A write with the soft-reset bit set sends a single-cycle reset pulse toward the pointer, status and parameter logic that lies outside this block. The control settings themselves are left untouched by that write, and the bit never has to be cleared by software. While the accelerator is running, the DMA enables are locked against writes. The current clipping mode is driven out so the datapath can choose between saturating and wrapping results that leave the q1.15 range.

Top module: `fltacc_ctrl`

## Requirements
- R1: After the synchronous active-high reset, `reg_rdata`, `irq`, `dma_rd_req`, `dma_wr_req`, `soft_rst` and `clip_mode` are all 0.
- R2: A write stores fields at these bit positions: output-ready interrupt enable at 0, input-space interrupt enable at 1, overflow enable at 2, underflow enable at 3, saturation enable at 4, DMA read enable at 8, DMA write enable at 9 and clip enable at 15. `reg_rdata` returns these fields at the same positions on the clock after the write. Every other bit, including the soft-reset bit 16, reads as 0.
- R3: With bit 0 set, `irq` is 1 one clock after `y_empty` is 0, and bit 0 alone gives no interrupt while `y_empty` is 1.
- R4: With bit 1 set, `irq` is 1 one clock after `x_full` is 0, and bit 1 alone gives no interrupt while `x_full` is 1.
- R5: With bits 2, 3 and 4 set, `irq` is 1 one clock after `ovfl_flag`, `unfl_flag` or `sat_flag` respectively is 1.
- R6: `irq` is the registered OR of the five enabled sources; a source whose enable is 0 has no effect on `irq`.
- R7: `dma_rd_req` is 1 one clock after bit 8 is set and `y_empty` is 0; `dma_wr_req` is 1 one clock after bit 9 is set and `x_full` is 0; otherwise each is 0.
- R8: While `run_active` is 1, a write leaves bits 8 and 9 at their old value, but the other fields of the same write are still stored.
- R9: A write with bit 16 set drives `soft_rst` to 1 for exactly the clock after the write and leaves every stored field unchanged. Any other write or idle cycle gives `soft_rst` = 0 on the next clock.
- R10: `clip_mode` equals the stored clip-enable bit 15 (1 = saturate, 0 = wrap).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Current control register contents |
| run_active | input | 1 | Accelerator running (start bit of parameter register) |
| y_empty | input | 1 | Output buffer empty flag |
| x_full | input | 1 | Input buffer full flag |
| ovfl_flag | input | 1 | Overflow error flag |
| unfl_flag | input | 1 | Underflow error flag |
| sat_flag | input | 1 | Saturation error flag |
| irq | output | 1 | Combined interrupt request |
| dma_rd_req | output | 1 | DMA read channel request |
| dma_wr_req | output | 1 | DMA write channel request |
| soft_rst | output | 1 | One-cycle reset pulse to pointer, status and parameter logic |
| clip_mode | output | 1 | 1 = saturate out-of-range results, 0 = wrap |

## Verification
The hardest case to reach is a write that mixes a locked field with free ones. The DMA enable lock must drop only bits 8 and 9 while `run_active` is high and still store the interrupt enables written in the same word. The bench raises `run_active` and writes a word that sets both DMA enables and an interrupt enable, then reads the register back. A soft-reset write is likewise issued on top of a non-zero register, so that the bench can see both that the stored settings survive and that the pulse lasts exactly one clock.

// File: rtl/fltacc_pkg.sv
package fltacc_pkg;
  localparam int N_IRQ_SRC = 5;
  localparam int BIT_IRQ_LO = 0;
  localparam int BIT_DMA_RD = 8;
  localparam int BIT_DMA_WR = 9;
  localparam int BIT_CLIP   = 15;
  localparam int BIT_SRST   = 16;

  // irq_en index: 0 out-ready, 1 in-space, 2 overflow, 3 underflow, 4 saturation
  typedef struct packed {
    logic                 clip;
    logic                 dma_wr;
    logic                 dma_rd;
    logic [N_IRQ_SRC-1:0] irq_en;
  } ctrl_t;
endpackage

// File: rtl/fltacc_regs.sv
module fltacc_regs
  import fltacc_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic          run_active,
  output ctrl_t         ctrl,
  output logic          srst_pulse
);
  localparam int IRQ_HI = BIT_IRQ_LO + N_IRQ_SRC - 1;

  logic srst_req;
  logic unused_wbits;
  assign srst_req     = wr_en && wdata[BIT_SRST];
  assign unused_wbits = ^wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl       <= '0;
      srst_pulse <= 1'b0;
    end else begin
      srst_pulse <= srst_req;
      if (wr_en && !srst_req) begin
        ctrl.irq_en <= wdata[IRQ_HI:BIT_IRQ_LO];
        ctrl.clip   <= wdata[BIT_CLIP];
        if (!run_active) begin
          ctrl.dma_rd <= wdata[BIT_DMA_RD];
          ctrl.dma_wr <= wdata[BIT_DMA_WR];
        end
      end
    end
  end

  assert_dma_lock_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && run_active) |=> (ctrl.dma_rd == $past(ctrl.dma_rd) && ctrl.dma_wr == $past(ctrl.dma_wr)));
  assert_srst_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wdata[BIT_SRST]) |=> srst_pulse);
  assert_srst_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wdata[BIT_SRST]) |=> !srst_pulse);
  assert_srst_keep_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wdata[BIT_SRST]) |=> $stable(ctrl));
endmodule

// File: rtl/fltacc_req.sv
module fltacc_req
  import fltacc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  ctrl_t ctrl,
  input  logic  y_empty,
  input  logic  x_full,
  input  logic  ovfl_flag,
  input  logic  unfl_flag,
  input  logic  sat_flag,
  output logic  irq,
  output logic  dma_rd_req,
  output logic  dma_wr_req
);
  logic [N_IRQ_SRC-1:0] cond;
  logic [N_IRQ_SRC-1:0] src;

  assign cond = {sat_flag, unfl_flag, ovfl_flag, !x_full, !y_empty};

  for (genvar i = 0; i < N_IRQ_SRC; i++) begin : g_src
    assign src[i] = ctrl.irq_en[i] & cond[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq        <= 1'b0;
      dma_rd_req <= 1'b0;
      dma_wr_req <= 1'b0;
    end else begin
      irq        <= |src;
      dma_rd_req <= ctrl.dma_rd && !y_empty;
      dma_wr_req <= ctrl.dma_wr && !x_full;
    end
  end

  assert_rd_irq_R3: assert property (@(posedge clk) disable iff (rst)
    (ctrl.irq_en[0] && !y_empty) |=> irq);
  assert_wr_irq_R4: assert property (@(posedge clk) disable iff (rst)
    (ctrl.irq_en[1] && !x_full) |=> irq);
  assert_no_src_R6: assert property (@(posedge clk) disable iff (rst)
    (ctrl.irq_en == '0) |=> !irq);
  assert_dma_rd_R7: assert property (@(posedge clk) disable iff (rst)
    y_empty |=> !dma_rd_req);
  assert_dma_wr_R7: assert property (@(posedge clk) disable iff (rst)
    x_full |=> !dma_wr_req);
endmodule

// File: rtl/fltacc_ctrl.sv
module fltacc_ctrl
  import fltacc_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr_en,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          run_active,
  input  logic          y_empty,
  input  logic          x_full,
  input  logic          ovfl_flag,
  input  logic          unfl_flag,
  input  logic          sat_flag,
  output logic          irq,
  output logic          dma_rd_req,
  output logic          dma_wr_req,
  output logic          soft_rst,
  output logic          clip_mode
);
  localparam int IRQ_HI = BIT_IRQ_LO + N_IRQ_SRC - 1;

  ctrl_t ctrl;

  fltacc_regs #(.DW(DW)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (reg_wr_en),
    .wdata      (reg_wdata),
    .run_active (run_active),
    .ctrl       (ctrl),
    .srst_pulse (soft_rst)
  );

  fltacc_req u_req (
    .clk        (clk),
    .rst        (rst),
    .ctrl       (ctrl),
    .y_empty    (y_empty),
    .x_full     (x_full),
    .ovfl_flag  (ovfl_flag),
    .unfl_flag  (unfl_flag),
    .sat_flag   (sat_flag),
    .irq        (irq),
    .dma_rd_req (dma_rd_req),
    .dma_wr_req (dma_wr_req)
  );

  always_comb begin
    reg_rdata                     = '0;
    reg_rdata[IRQ_HI:BIT_IRQ_LO]  = ctrl.irq_en;
    reg_rdata[BIT_DMA_RD]         = ctrl.dma_rd;
    reg_rdata[BIT_DMA_WR]         = ctrl.dma_wr;
    reg_rdata[BIT_CLIP]           = ctrl.clip;
  end

  assign clip_mode = ctrl.clip;

  assert_srst_reads0_R2: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[BIT_SRST] == 1'b0);
  assert_clip_out_R10: assert property (@(posedge clk) disable iff (rst)
    clip_mode == reg_rdata[BIT_CLIP]);
endmodule

// File: tb/fltacc_ctrl_bench.sv
`timescale 1ns/1ps
module fltacc_ctrl_bench;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic          reg_wr_en;
  logic [DW-1:0] reg_wdata;
  logic [DW-1:0] reg_rdata;
  logic          run_active, y_empty, x_full, ovfl_flag, unfl_flag, sat_flag;
  logic          irq, dma_rd_req, dma_wr_req, soft_rst, clip_mode;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  fltacc_ctrl #(.DW(DW)) u_fltacc_ctrl (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .run_active(run_active), .y_empty(y_empty),
    .x_full(x_full), .ovfl_flag(ovfl_flag), .unfl_flag(unfl_flag),
    .sat_flag(sat_flag), .irq(irq), .dma_rd_req(dma_rd_req),
    .dma_wr_req(dma_wr_req), .soft_rst(soft_rst), .clip_mode(clip_mode)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // drive at a falling edge, return at the falling edge after the capture edge
  task automatic wr(input logic [DW-1:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1;
    reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
    reg_wdata = '0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle_flags();
    y_empty = 1'b1; x_full = 1'b1;
    ovfl_flag = 1'b0; unfl_flag = 1'b0; sat_flag = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 rdata", reg_rdata, 0);
    check("R1 irq", irq, 0);
    check("R1 dma_rd", dma_rd_req, 0);
    check("R1 dma_wr", dma_wr_req, 0);
    check("R1 soft_rst", soft_rst, 0);
    check("R1 clip", clip_mode, 0);
  endtask

  task automatic t_readback();
    wr(32'hFFFE_FFFF);
    check("R2 readback all", reg_rdata, 32'h0000_831F);
    check("R10 clip on", clip_mode, 1);
    wr(32'h0000_0204);
    check("R2 readback sparse", reg_rdata, 32'h0000_0204);
    check("R10 clip off", clip_mode, 0);
    wr(0);
    step();
  endtask

  task automatic t_rd_irq();
    idle_flags();
    wr(32'h1);
    step();
    check("R3 empty no irq", irq, 0);
    y_empty = 1'b0; step();
    check("R3 data irq", irq, 1);
    y_empty = 1'b1; step();
    check("R3 irq drops", irq, 0);
  endtask

  task automatic t_wr_irq();
    idle_flags();
    wr(32'h2);
    step();
    check("R4 full no irq", irq, 0);
    x_full = 1'b0; step();
    check("R4 space irq", irq, 1);
    x_full = 1'b1; step();
    check("R4 irq drops", irq, 0);
  endtask

  task automatic t_err_irq();
    idle_flags();
    wr(32'h1C);
    ovfl_flag = 1'b1; step();
    check("R5 overflow", irq, 1);
    ovfl_flag = 1'b0; unfl_flag = 1'b1; step();
    check("R5 underflow", irq, 1);
    unfl_flag = 1'b0; sat_flag = 1'b1; step();
    check("R5 saturation", irq, 1);
    sat_flag = 1'b0; step();
    check("R5 clear", irq, 0);
    // R6: all sources active but only the saturation enable set
    wr(32'h10);
    y_empty = 1'b0; x_full = 1'b0; ovfl_flag = 1'b1; unfl_flag = 1'b1; step();
    check("R6 masked sources", irq, 0);
    sat_flag = 1'b1; step();
    check("R6 or of enabled", irq, 1);
    wr(0);
    step();
    check("R6 all disabled", irq, 0);
    idle_flags();
  endtask

  task automatic t_dma();
    idle_flags();
    run_active = 1'b0;
    wr(32'h300);
    step();
    check("R7 rd idle", dma_rd_req, 0);
    check("R7 wr idle", dma_wr_req, 0);
    y_empty = 1'b0; step();
    check("R7 rd req", dma_rd_req, 1);
    check("R7 wr still full", dma_wr_req, 0);
    y_empty = 1'b1; x_full = 1'b0; step();
    check("R7 rd drop", dma_rd_req, 0);
    check("R7 wr req", dma_wr_req, 1);
    wr(32'h100);
    step();
    check("R7 wr disabled", dma_wr_req, 0);
    wr(0);
    idle_flags();
  endtask

  task automatic t_lock();
    run_active = 1'b1;
    wr(32'h0000_0301);
    check("R8 locked keeps dma, stores irq en", reg_rdata, 32'h1);
    run_active = 1'b0;
    wr(32'h0000_0300);
    check("R8 unlocked", reg_rdata, 32'h300);
    run_active = 1'b1;
    wr(32'h0000_8002);
    check("R8 locked clear kept", reg_rdata, 32'h8302);
    run_active = 1'b0;
    wr(0);
  endtask

  task automatic t_soft_rst();
    wr(32'h0000_8013);
    check("R9 no pulse on plain write", soft_rst, 0);
    wr(32'h0001_0000);
    check("R9 pulse", soft_rst, 1);
    check("R9 fields kept", reg_rdata, 32'h8013);
    step();
    check("R9 pulse one cycle", soft_rst, 0);
    wr(32'hFFFF_FFFF);
    check("R9 mixed write kept", reg_rdata, 32'h8013);
    check("R2 srst reads 0", reg_rdata[16], 0);
    step();
    check("R9 pulse ended", soft_rst, 0);
    wr(0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    rst = 1'b1; reg_wr_en = 1'b0; reg_wdata = '0; run_active = 1'b0;
    idle_flags();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    step();
    t_reset();
    t_readback();
    t_rd_irq();
    t_wr_irq();
    t_err_irq();
    t_dma();
    t_lock();
    t_soft_rst();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule